// File: doc/BRIEF.md
# PWM Dead-Time Generator

This block shapes a pair of raw PWM streams, A and B, into a pair of output streams suitable for driving the two switches of a half bridge. It has two delay units. The rising-edge unit holds back the rising edges of its source. The falling-edge unit holds back the falling edges of its source. Each unit picks stream A or stream B as its source, and each unit can invert its result. After the delay units, each output path can skip the delay logic. A swap stage then exchanges the two outputs or copies one into the other.

All timing is counted in delay ticks. A control bit chooses the source of these ticks: either the main clock-enable `tick_i` or a second enable `alt_tick_i`. For each stream, a timer counts how many ticks the stream has held its present level. The timer restarts on every edge of that stream. The delay units compare this count against the programmed delays. The delay, invert, bypass and swap controls are combinational, so a configuration change takes effect immediately.

Top module: `pwm_deadtime_gen`

## Requirements
- R1: Control bits are at these positions of `ctrl_i`: 17 tick select, 16 B-bypass, 15 A-bypass, 14 fall-unit invert, 13 rise-unit invert, 12 fall-unit source, 11 rise-unit source, 10 B-swap, 9 A-swap. With bits 16 and 15 set and both swap bits clear, `out_a_o` equals `pwm_a_i` and `out_b_o` equals `pwm_b_i`.
- R2: A source bit of 0 selects stream A for that unit, and a source bit of 1 selects stream B.
- R3: The rise-unit output goes high only after its source has been sampled high on `rise_dly_i` consecutive ticks. It goes low in the same cycle that the source goes low. A high pulse shorter than the delay never appears at the output.
- R4: The fall-unit output goes low only after its source has been sampled low on `fall_dly_i` consecutive ticks. It goes high in the same cycle that the source goes high. A low pulse shorter than the delay never appears at the output.
- R5: A delay of 0 passes the source through unchanged. The tick count of a stream restarts on every edge of that stream.
- R6: Invert bit 13 inverts the rise-unit result, and invert bit 14 inverts the fall-unit result.
- R7: The path for A carries the rise-unit result, and the path for B carries the fall-unit result. A set bypass bit replaces that path with its raw input stream. Swap still applies to a bypassed path.
- R8: With both swap bits set, the two paths are exchanged. With only the A-swap bit set, both outputs carry path B. With only the B-swap bit set, both outputs carry path A.
- R9: With only bit 14 set, `out_b_o` is the complement of `out_a_o`, except during each dead gap, when both outputs are low. The two outputs are never high together.
- R10: Tick select 0 counts on `tick_i`, and tick select 1 counts on `alt_tick_i`. No tick count advances without a selected tick.
- R11: After reset, each stream's timer reads as settled at its low level. With default controls and low inputs, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Main delay-clock enable |
| alt_tick_i | input | 1 | Alternate delay-clock enable |
| ctrl_i | input | 9 | Control bits 17..9 |
| rise_dly_i | input | 16 | Rising-edge delay in ticks |
| fall_dly_i | input | 16 | Falling-edge delay in ticks |
| pwm_a_i | input | 1 | Raw stream A |
| pwm_b_i | input | 1 | Raw stream B |
| out_a_o | output | 1 | Shaped output A |
| out_b_o | output | 1 | Shaped output B |

## Verification
The hardest case to reach is a pulse that ends within a tick or two of the programmed delay. Only this case separates a correct restart-on-edge count from one that is off by one, or one that fails to restart. The stimulus toggles each stream with a pseudo-random pattern of short and long runs. This places pulses just below, at and above the delays. The ticks are thinned to every second or third cycle, so an input may change more than once between two ticks. Every cycle is compared against a model that tracks run lengths per stream, across all routing, invert, bypass, swap and tick-select settings.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  localparam int CFG_LSB  = 9;
  localparam int CFG_MSB  = 17;
  localparam int CFG_W    = CFG_MSB - CFG_LSB + 1;
  localparam int TICK_SEL = 17;
  localparam int BYP_B    = 16;
  localparam int BYP_A    = 15;
  localparam int INV_FALL = 14;
  localparam int INV_RISE = 13;
  localparam int SRC_FALL = 12;
  localparam int SRC_RISE = 11;
  localparam int SWP_B    = 10;
  localparam int SWP_A    = 9;

  typedef struct packed {
    logic tick_alt;
    logic byp_b;
    logic byp_a;
    logic inv_fall;
    logic inv_rise;
    logic src_fall;
    logic src_rise;
    logic swp_b;
    logic swp_a;
  } dt_ctrl_t;

  function automatic dt_ctrl_t decode_ctrl(input logic [CFG_MSB:CFG_LSB] w);
    dt_ctrl_t c;
    c.tick_alt = w[TICK_SEL];
    c.byp_b    = w[BYP_B];
    c.byp_a    = w[BYP_A];
    c.inv_fall = w[INV_FALL];
    c.inv_rise = w[INV_RISE];
    c.src_fall = w[SRC_FALL];
    c.src_rise = w[SRC_RISE];
    c.swp_b    = w[SWP_B];
    c.swp_a    = w[SWP_A];
    return c;
  endfunction
endpackage

// File: rtl/pwm_dt_run_timer.sv
// Counts ticks the input has held its level; restarts on each edge.
module pwm_dt_run_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             lvl_i,
  output logic [CNT_W-1:0] run_o
);
  localparam logic [CNT_W-1:0] RUN_MAX = '1;
  localparam logic [CNT_W-1:0] RUN_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic             lvl_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      cnt_q <= RUN_MAX;
    end else if (tick_i) begin
      if (lvl_i != lvl_q) begin
        lvl_q <= lvl_i;
        cnt_q <= RUN_ONE;
      end else if (cnt_q != RUN_MAX) begin
        cnt_q <= cnt_q + RUN_ONE;
      end
    end
  end

  // an edge not yet seen by a tick counts as zero elapsed ticks
  assign run_o = (lvl_i == lvl_q) ? cnt_q : '0;

  AST_HOLD_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(cnt_q) && $stable(lvl_q))); // R10

  AST_EDGE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && (lvl_i != lvl_q)) |=> (run_o <= RUN_ONE)); // R5
endmodule

// File: rtl/pwm_dt_shaper.sv
// One delay unit: RISE=1 holds back rising edges, RISE=0 falling edges.
module pwm_dt_shaper #(
  parameter bit RISE  = 1'b1,
  parameter int CNT_W = 16
) (
  input  logic             src_i,
  input  logic [CNT_W-1:0] run_i,
  input  logic [CNT_W-1:0] dly_i,
  input  logic             inv_i,
  output logic             y_o
);
  logic settled;
  logic y_raw;

  assign settled = (run_i >= dly_i);

  generate
    if (RISE) begin : g_rise
      assign y_raw = src_i & settled;
    end else begin : g_fall
      assign y_raw = src_i | ~settled;
    end
  endgenerate

  assign y_o = y_raw ^ inv_i;
endmodule

// File: rtl/pwm_dt_route.sv
module pwm_dt_route
  import pwm_dt_pkg::*;
(
  input  dt_ctrl_t ctrl_i,
  input  logic     raw_a_i,
  input  logic     raw_b_i,
  input  logic     rise_i,
  input  logic     fall_i,
  output logic     out_a_o,
  output logic     out_b_o
);
  logic path_a, path_b;

  assign path_a  = ctrl_i.byp_a ? raw_a_i : rise_i;
  assign path_b  = ctrl_i.byp_b ? raw_b_i : fall_i;
  assign out_a_o = ctrl_i.swp_a ? path_b : path_a;
  assign out_b_o = ctrl_i.swp_b ? path_a : path_b;
endmodule

// File: rtl/pwm_deadtime_gen.sv
module pwm_deadtime_gen
  import pwm_dt_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tick_i,
  input  logic                   alt_tick_i,
  input  logic [CFG_MSB:CFG_LSB] ctrl_i,
  input  logic [DLY_W-1:0]       rise_dly_i,
  input  logic [DLY_W-1:0]       fall_dly_i,
  input  logic                   pwm_a_i,
  input  logic                   pwm_b_i,
  output logic                   out_a_o,
  output logic                   out_b_o
);
  localparam int N_STREAM = 2;
  localparam int N_UNIT   = 2;

  dt_ctrl_t         ctrl;
  logic             dly_tick;
  logic [N_STREAM-1:0] raw;
  logic [DLY_W-1:0] run   [N_STREAM];
  logic [N_UNIT-1:0]   u_sel, u_inv, u_src, u_y;
  logic [DLY_W-1:0] u_run [N_UNIT];
  logic [DLY_W-1:0] u_dly [N_UNIT];

  assign ctrl     = decode_ctrl(ctrl_i);
  assign dly_tick = ctrl.tick_alt ? alt_tick_i : tick_i;
  assign raw      = {pwm_b_i, pwm_a_i};

  generate
    for (genvar s = 0; s < N_STREAM; s++) begin : g_stream
      pwm_dt_run_timer #(.CNT_W(DLY_W)) u_run_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (dly_tick),
        .lvl_i  (raw[s]),
        .run_o  (run[s])
      );
    end
  endgenerate

  // unit 0 = rising-edge delay, unit 1 = falling-edge delay
  assign u_sel    = {ctrl.src_fall, ctrl.src_rise};
  assign u_inv    = {ctrl.inv_fall, ctrl.inv_rise};
  assign u_dly[0] = rise_dly_i;
  assign u_dly[1] = fall_dly_i;

  generate
    for (genvar u = 0; u < N_UNIT; u++) begin : g_unit
      assign u_src[u] = raw[u_sel[u]];
      assign u_run[u] = run[u_sel[u]];
      pwm_dt_shaper #(.RISE(u == 0), .CNT_W(DLY_W)) u_shaper (
        .src_i (u_src[u]),
        .run_i (u_run[u]),
        .dly_i (u_dly[u]),
        .inv_i (u_inv[u]),
        .y_o   (u_y[u])
      );
    end
  endgenerate

  pwm_dt_route u_route (
    .ctrl_i  (ctrl),
    .raw_a_i (pwm_a_i),
    .raw_b_i (pwm_b_i),
    .rise_i  (u_y[0]),
    .fall_i  (u_y[1]),
    .out_a_o (out_a_o),
    .out_b_o (out_b_o)
  );

  AST_BYPASS_THRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[BYP_A] && ctrl_i[BYP_B] && !ctrl_i[SWP_A] && !ctrl_i[SWP_B])
      |-> (out_a_o == pwm_a_i && out_b_o == pwm_b_i)); // R1

  AST_SWAP_BYPASSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[BYP_A] && ctrl_i[BYP_B] && ctrl_i[SWP_A] && ctrl_i[SWP_B])
      |-> (out_a_o == pwm_b_i && out_b_o == pwm_a_i)); // R8

  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[CFG_MSB-1:CFG_LSB] == 8'(1 << (INV_FALL - CFG_LSB)))
      |-> !(out_a_o && out_b_o)); // R9
endmodule

// File: tb/test_pwm_deadtime_gen.sv
`timescale 1ns/1ps
module test_pwm_deadtime_gen;
  localparam int RMAX = 65535;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, alt = 1'b0;
  logic [17:9] ctrl = '0;
  logic [15:0] dr = '0, df = '0;
  logic        pa = 1'b0, pb = 1'b0;
  logic        oa, ob;

  int    checks = 0, fails = 0;
  int    lvl [2];
  int    cnt [2];
  string req = "R11";
  bit    ahc_chk = 1'b0;
  bit    done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  pwm_deadtime_gen i_pwm_deadtime_gen (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .alt_tick_i(alt),
    .ctrl_i(ctrl), .rise_dly_i(dr), .fall_dly_i(df),
    .pwm_a_i(pa), .pwm_b_i(pb), .out_a_o(oa), .out_b_o(ob)
  );

  // reference model: per-stream run length in selected ticks
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < 2; s++) begin lvl[s] = 0; cnt[s] = RMAX; end
    end else if (ctrl[17] ? alt : tick) begin
      for (int s = 0; s < 2; s++) begin
        int x;
        x = (s == 0) ? int'(pa) : int'(pb);
        if (x != lvl[s]) begin lvl[s] = x; cnt[s] = 1; end
        else if (cnt[s] < RMAX) cnt[s]++;
      end
    end
  end

  function automatic int elapsed(int s, logic x);
    return (int'(x) == lvl[s]) ? cnt[s] : 0;
  endfunction

  task automatic expect_out(output logic ea, output logic eb);
    logic rs, fs, rr, ff, qa, qb;
    int   re, fe;
    rs = ctrl[11] ? pb : pa;  re = elapsed(ctrl[11] ? 1 : 0, rs);
    fs = ctrl[12] ? pb : pa;  fe = elapsed(ctrl[12] ? 1 : 0, fs);
    rr = (rs && re >= int'(dr)) ^ ctrl[13];          // delayed rise
    ff = (fs || fe < int'(df)) ^ ctrl[14];           // delayed fall
    qa = ctrl[15] ? pa : rr;
    qb = ctrl[16] ? pb : ff;
    ea = ctrl[9]  ? qb : qa;
    eb = ctrl[10] ? qa : qb;
  endtask

  task automatic step(input logic a, input logic b, input logic t, input logic at);
    logic ea, eb;
    @(negedge clk);
    pa = a; pb = b; tick = t; alt = at;
    #1;
    expect_out(ea, eb);
    checks++;
    if (oa !== ea || ob !== eb) begin
      fails++;
      $display("FAIL %s: out a/b = %b%b expected %b%b", req, oa, ob, ea, eb);
    end
    if (ahc_chk) begin
      checks++;
      if (oa && ob) begin
        fails++;
        $display("FAIL R9: out a/b = %b%b expected not both high", oa, ob);
      end
    end
  endtask

  task automatic run_phase(input string r, input logic [17:9] c,
                           input int rd, input int fd, input int n, input int div);
    logic a, b;
    req = r; ctrl = c; dr = 16'(rd); df = 16'(fd);
    a = pa; b = pb;
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] == 3'd0) a = ~a;
      if (lfsr[6:4] == 3'd1) b = ~b;
      step(a, b, (i % div) == 0, (i % 3) == 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: done = 0 expected 1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    dr = 16'd3; df = 16'd5;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R11";
    step(1'b0, 1'b0, 1'b0, 1'b0);               // R11 settled low after reset
    run_phase("R1",  9'b0_1100_0000, 4, 4, 200, 1);
    run_phase("R3",  9'b0_0000_0000, 3, 0, 300, 1);
    run_phase("R4",  9'b0_0000_0000, 0, 5, 300, 2);
    run_phase("R3",  9'b0_0000_0000, 6, 4, 300, 2);
    run_phase("R5",  9'b0_0000_0000, 0, 0, 200, 1);
    run_phase("R2",  9'b0_0000_1100, 3, 4, 300, 1);
    run_phase("R2",  9'b0_0000_1000, 2, 5, 300, 1);
    run_phase("R6",  9'b0_0011_0000, 3, 2, 300, 1);
    run_phase("R7",  9'b0_0100_0001, 4, 3, 300, 1);
    run_phase("R7",  9'b0_1000_0011, 4, 3, 200, 1);
    run_phase("R8",  9'b0_0000_0011, 3, 3, 200, 1);
    run_phase("R8",  9'b0_0000_0001, 3, 3, 200, 1);
    run_phase("R8",  9'b0_0000_0010, 3, 3, 200, 1);
    ahc_chk = 1'b1;
    run_phase("R9",  9'b0_0010_0000, 4, 4, 400, 1);
    run_phase("R9",  9'b0_0010_0000, 2, 6, 300, 2);
    ahc_chk = 1'b0;
    run_phase("R10", 9'b1_0000_0000, 3, 4, 400, 1);
    run_phase("R10", 9'b1_0010_0000, 5, 2, 300, 2);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule